// File: doc/BRIEF.md
# Programmable Timer Time Base

This block is a 16-bit time base for a general-purpose timer. A 16-bit clock divider turns the system clock into count-enable ticks. A counter advances on each tick in one of three ways: it rises to a programmed period and wraps to zero, it falls from the period to zero and reloads, or it swings up and down between zero and the period. Each wrap or turnaround produces a one-cycle overflow or underflow pulse. These pulses also set a sticky event flag that software clears.

The period may be written straight into the live register, or held in a shadow copy until the next wrap event. A single compare channel sets its own sticky flag when the count matches the compare value. In the up/down modes, the mode code limits this match to the falling half, to the rising half, or allows it in both halves.

Software writes four registers through one write port: control, period, divider and compare. The live count, the direction and both flags are always visible on the outputs.

Top module: `tbase_timer`

## Requirements
- R1: After reset the count is 0, the direction output is 0 (up), both flags and both event pulses are 0, the period is 0xFFFF, and the divider and compare values are 0.
- R2: With divider value D (register select 2), the counter steps once every D+1 clocks while the enable bit (control bit 0) is set. It holds its value while the enable bit is clear. The divider restarts from zero when counting is enabled, so the first step after enabling comes D+1 clocks after the enabling write.
- R3: In edge mode (control bits [3:2] = 00) with direction bit (control bit 1) = 0, the counter rises by one per tick. On the tick where the count is at or above the period, it returns to 0 and pulses the overflow output.
- R4: In edge mode with direction bit = 1, the counter falls by one per tick. On the tick where the count is 0, it reloads the period value and pulses the underflow output.
- R5: In up/down mode (control bits [3:2] ≠ 00) while rising, the tick at which the count is period−1 moves the count to the period value, sets the direction to down and pulses overflow.
- R6: In up/down mode while falling, the tick at which the count is 1 moves the count to 0, sets the direction to up and pulses underflow.
- R7: The direction output shows the current counting direction (1 = down). A control write loads the direction bit only when the written mode is edge mode. In up/down mode such writes leave the direction unchanged.
- R8: With the period-buffer bit (control bit 4) clear, a period write (register select 1) governs the very next tick.
- R9: With the period-buffer bit set, a written period is held aside and becomes live only at the next overflow or underflow.
- R10: The compare flag is set on a tick at which the count equals the compare value (register select 3), subject to the mode. Modes 00 and 11 allow the match in either direction, mode 01 only while falling, and mode 10 only while rising.
- R11: The event flag is set on every overflow or underflow and stays set until a clear pulse. A set in the same cycle as a clear wins.
- R12: The overflow and underflow outputs are single-cycle pulses that appear together with the updated count and never at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 period, 2 divider, 3 compare |
| wr_data | input | 16 | Write data |
| evt_clr | input | 1 | Clears the event flag |
| cmp_clr | input | 1 | Clears the compare flag |
| cnt_o | output | 16 | Live count |
| dir_o | output | 1 | Counting direction, 1 = down |
| evt_flag_o | output | 1 | Sticky overflow/underflow flag |
| cmp_flag_o | output | 1 | Sticky compare flag |
| ovf_o | output | 1 | Overflow pulse |
| unf_o | output | 1 | Underflow pulse |

## Verification
A wrong divider phase shows on the count within one divided period, as a step that comes one or more clocks early or late. A wrong direction or turnaround state shows one tick later, as a count that moves the wrong way or runs past the period, and the direction output and the event pulses expose it in the same cycle. A stale live period or a stale shadow period goes unnoticed until the next wrap, where the count either wraps at the wrong value or fails to wrap. The bench therefore samples just around each wrap. Compare-rule errors show only on the tick where the count passes the compare value in the excluded direction, so the bench places matches in both halves of the up/down sweep.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  localparam int unsigned CTL_EN   = 0;
  localparam int unsigned CTL_DIR  = 1;
  localparam int unsigned CTL_MLO  = 2;
  localparam int unsigned CTL_PBUF = 4;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_PER  = 2'd1,
    SEL_DIV  = 2'd2,
    SEL_CMP  = 2'd3
  } regsel_e;

  typedef enum logic [1:0] {
    MODE_EDGE  = 2'b00,
    MODE_CDN   = 2'b01,
    MODE_CUP   = 2'b10,
    MODE_CBOTH = 2'b11
  } cmode_e;
endpackage

// File: rtl/tbase_prescaler.sv
module tbase_prescaler #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [DW-1:0] div_i,
  output logic          tick_o
);
  logic [DW-1:0] pcnt_q, pcnt_d;
  logic          pcnt_upd;

  assign tick_o   = en_i && (pcnt_q >= div_i);
  assign pcnt_upd = en_i || (pcnt_q != '0);

  always_comb begin
    if (!en_i)       pcnt_d = '0;
    else if (tick_o) pcnt_d = '0;
    else             pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pcnt_q <= '0;
    else if (pcnt_upd) pcnt_q <= pcnt_d;
  end

  AST_PRE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (pcnt_q == '0)); // R2
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter
  import tbase_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  cmode_e        mode_i,
  input  logic          pbuf_i,
  input  logic          per_wr_i,
  input  logic          ctl_wr_i,
  input  logic          ctl_dir_i,
  input  cmode_e        ctl_mode_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] cnt_o,
  output logic          dir_o,
  output logic          evt_now_o,
  output logic          ovf_o,
  output logic          unf_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] per_act_q, per_act_d, per_pend_q;
  logic          dir_q, dir_d, dir_nx;
  logic          ovf_c, unf_c, ovf_q, unf_q;
  logic          per_act_upd;

  // next count, direction and wrap events for one tick
  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    ovf_c = 1'b0;
    unf_c = 1'b0;
    if (mode_i == MODE_EDGE) begin
      if (!dir_q) begin
        if (cnt_q >= per_act_q) begin
          cnt_d = '0;
          ovf_c = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == '0) begin
          cnt_d = per_act_q;
          unf_c = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end else if (per_act_q != '0) begin
      if (!dir_q) begin
        if (cnt_q >= per_act_q - 1'b1) begin
          cnt_d = per_act_q;
          dir_d = 1'b1;
          ovf_c = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q <= {{(CW-1){1'b0}}, 1'b1}) begin
          cnt_d = '0;
          dir_d = 1'b0;
          unf_c = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end else begin
      cnt_d = '0;
    end
  end

  assign evt_now_o = tick_i && (ovf_c || unf_c);

  // direction: software loads it only in edge mode
  always_comb begin
    if (ctl_wr_i && (ctl_mode_i == MODE_EDGE)) dir_nx = ctl_dir_i;
    else if (tick_i)                           dir_nx = dir_d;
    else                                       dir_nx = dir_q;
  end

  // live period: direct write or shadow transfer at a wrap
  assign per_act_upd = (per_wr_i && !pbuf_i) || (evt_now_o && pbuf_i);
  assign per_act_d   = (per_wr_i && !pbuf_i) ? wdata_i : per_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      dir_q      <= 1'b0;
      ovf_q      <= 1'b0;
      unf_q      <= 1'b0;
      per_act_q  <= '1;
      per_pend_q <= '1;
    end else begin
      if (tick_i)      cnt_q      <= cnt_d;
      dir_q <= dir_nx;
      ovf_q <= tick_i && ovf_c;
      unf_q <= tick_i && unf_c;
      if (per_wr_i)    per_pend_q <= wdata_i;
      if (per_act_upd) per_act_q  <= per_act_d;
    end
  end

  assign cnt_o = cnt_q;
  assign dir_o = dir_q;
  assign ovf_o = ovf_q;
  assign unf_o = unf_q;

  AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q)); // R2
  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && mode_i == MODE_EDGE && !dir_q && cnt_q >= per_act_q) |=> (cnt_q == '0 && ovf_q)); // R3
  AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && mode_i == MODE_EDGE && dir_q && cnt_q == '0) |=> (unf_q && cnt_q == $past(per_act_q))); // R4
  AST_CTR_TOP_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !ctl_wr_i && mode_i != MODE_EDGE && !dir_q && per_act_q != '0 && cnt_q == per_act_q - 1'b1)
      |=> (dir_q && ovf_q)); // R5
  AST_CTR_BOT_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !ctl_wr_i && mode_i != MODE_EDGE && dir_q && per_act_q != '0 && cnt_q == 1)
      |=> (!dir_q && unf_q && cnt_q == '0)); // R6
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_q && unf_q)); // R12
endmodule

// File: rtl/tbase_compare.sv
module tbase_compare
  import tbase_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  cmode_e        mode_i,
  input  logic          dir_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] cmp_i,
  input  logic          clr_i,
  output logic          flag_o
);
  logic flag_q, flag_d, dir_ok, hit;

  always_comb begin
    unique case (mode_i)
      MODE_CDN: dir_ok = dir_i;
      MODE_CUP: dir_ok = !dir_i;
      default:  dir_ok = 1'b1;
    endcase
  end

  assign hit = tick_i && (cnt_i == cmp_i) && dir_ok;

  always_comb begin
    if (hit)        flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
    else            flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  AST_CMP_DOWN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_q) && $past(mode_i) == MODE_CDN) |-> $past(dir_i)); // R10
  AST_CMP_UP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_q) && $past(mode_i) == MODE_CUP) |-> !$past(dir_i)); // R10
endmodule

// File: rtl/tbase_timer.sv
module tbase_timer
  import tbase_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic          evt_clr,
  input  logic          cmp_clr,
  output logic [CW-1:0] cnt_o,
  output logic          dir_o,
  output logic          evt_flag_o,
  output logic          cmp_flag_o,
  output logic          ovf_o,
  output logic          unf_o
);
  logic   rst_s1, rst_s2;
  logic   ctl_wr, per_wr, div_wr, cmp_wr;
  logic   en_q, pbuf_q;
  cmode_e mode_q, wr_mode;
  logic [CW-1:0] div_q, cmp_q;
  logic   tick, evt_now, evt_flag_q, evt_flag_d;
  logic [CW-1:0] cnt_w;
  logic   dir_w;

  // reset: asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  assign ctl_wr  = wr_en && (regsel_e'(wr_sel) == SEL_CTRL);
  assign per_wr  = wr_en && (regsel_e'(wr_sel) == SEL_PER);
  assign div_wr  = wr_en && (regsel_e'(wr_sel) == SEL_DIV);
  assign cmp_wr  = wr_en && (regsel_e'(wr_sel) == SEL_CMP);
  assign wr_mode = cmode_e'(wr_data[CTL_MLO+1:CTL_MLO]);

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) begin
      en_q   <= 1'b0;
      pbuf_q <= 1'b0;
      mode_q <= MODE_EDGE;
      div_q  <= '0;
      cmp_q  <= '0;
    end else begin
      if (ctl_wr) begin
        en_q   <= wr_data[CTL_EN];
        pbuf_q <= wr_data[CTL_PBUF];
        mode_q <= wr_mode;
      end
      if (div_wr) div_q <= wr_data;
      if (cmp_wr) cmp_q <= wr_data;
    end
  end

  tbase_prescaler #(.DW(CW)) u_pre (
    .clk    (clk),
    .rst_n  (rst_s2),
    .en_i   (en_q),
    .div_i  (div_q),
    .tick_o (tick)
  );

  tbase_counter #(.CW(CW)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_s2),
    .tick_i     (tick),
    .mode_i     (mode_q),
    .pbuf_i     (pbuf_q),
    .per_wr_i   (per_wr),
    .ctl_wr_i   (ctl_wr),
    .ctl_dir_i  (wr_data[CTL_DIR]),
    .ctl_mode_i (wr_mode),
    .wdata_i    (wr_data),
    .cnt_o      (cnt_w),
    .dir_o      (dir_w),
    .evt_now_o  (evt_now),
    .ovf_o      (ovf_o),
    .unf_o      (unf_o)
  );

  tbase_compare #(.CW(CW)) u_cmp (
    .clk    (clk),
    .rst_n  (rst_s2),
    .tick_i (tick),
    .mode_i (mode_q),
    .dir_i  (dir_w),
    .cnt_i  (cnt_w),
    .cmp_i  (cmp_q),
    .clr_i  (cmp_clr),
    .flag_o (cmp_flag_o)
  );

  always_comb begin
    if (evt_now)      evt_flag_d = 1'b1;
    else if (evt_clr) evt_flag_d = 1'b0;
    else              evt_flag_d = evt_flag_q;
  end

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) evt_flag_q <= 1'b0;
    else         evt_flag_q <= evt_flag_d;
  end

  assign cnt_o      = cnt_w;
  assign dir_o      = dir_w;
  assign evt_flag_o = evt_flag_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_s2)
    (evt_flag_q && !evt_clr) |=> evt_flag_q); // R11
  AST_FLAG_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_s2)
    (ovf_o || unf_o) |-> evt_flag_q); // R11
  AST_DIR_LOCKED: assert property (@(posedge clk) disable iff (!rst_s2)
    (ctl_wr && wr_mode != MODE_EDGE && !tick) |=> $stable(dir_w)); // R7
endmodule

// File: tb/tbase_timer_tb.sv
module tbase_timer_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 10;

  typedef struct packed {
    logic [4:0]  ctrl;
    logic [15:0] per;
    logic [15:0] div;
    logic [15:0] cmp;
    logic [7:0]  n;
    logic [15:0] exp_cnt;
    logic        exp_dir;
    logic        exp_evt;
    logic        exp_cmp;
    logic [3:0]  req;
  } vec_t;

  // ctrl: bit0 enable, bit1 direction, bits[3:2] mode, bit4 period buffer
  localparam vec_t VECS [NVEC] = '{
    '{5'h01, 16'd5,   16'd0, 16'd3,  8'd3,  16'd3, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 rising, no wrap
    '{5'h01, 16'd5,   16'd0, 16'd3,  8'd7,  16'd1, 1'b0, 1'b1, 1'b1, 4'd3},  // R3 wrap, R10 edge mode
    '{5'h03, 16'd5,   16'd0, 16'd5,  8'd2,  16'd4, 1'b1, 1'b1, 1'b1, 4'd4},  // R4 reload from 0
    '{5'h0D, 16'd4,   16'd0, 16'd3,  8'd6,  16'd2, 1'b1, 1'b1, 1'b1, 4'd5},  // R5 top turn
    '{5'h05, 16'd4,   16'd0, 16'd3,  8'd4,  16'd4, 1'b1, 1'b1, 1'b0, 4'd10}, // R10 down-only, rising match ignored
    '{5'h05, 16'd4,   16'd0, 16'd3,  8'd6,  16'd2, 1'b1, 1'b1, 1'b1, 4'd10}, // R10 down-only, falling match
    '{5'h09, 16'd4,   16'd0, 16'd3,  8'd4,  16'd4, 1'b1, 1'b1, 1'b1, 4'd10}, // R10 up-only, rising match
    '{5'h09, 16'd4,   16'd0, 16'd4,  8'd8,  16'd0, 1'b0, 1'b1, 1'b0, 4'd6},  // R6 bottom turn, R10 up-only
    '{5'h01, 16'd100, 16'd3, 16'd50, 8'd11, 16'd2, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 divide by 4
    '{5'h0D, 16'd1,   16'd0, 16'd0,  8'd3,  16'd1, 1'b1, 1'b1, 1'b1, 4'd5}   // R5 R6 period 1
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        evt_clr = 1'b0;
  logic        cmp_clr = 1'b0;
  logic [15:0] cnt_o;
  logic        dir_o, evt_flag_o, cmp_flag_o, ovf_o, unf_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tbase_timer dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .evt_clr    (evt_clr),
    .cmp_clr    (cmp_clr),
    .cnt_o      (cnt_o),
    .dir_o      (dir_o),
    .evt_flag_o (evt_flag_o),
    .cmp_flag_o (cmp_flag_o),
    .ovf_o      (ovf_o),
    .unf_o      (unf_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 cnt", cnt_o, 0);
    chk("R1 dir", dir_o, 0);
    chk("R1 evt", evt_flag_o, 0);
    chk("R1 cmp", cmp_flag_o, 0);
    chk("R1 ovf", ovf_o, 0);
    chk("R1 unf", unf_o, 0);

    for (int i = 0; i < NVEC; i++) begin
      string tg;
      tg = $sformatf("vec%0d R%0d", i, VECS[i].req);
      do_reset();
      wr(2'd1, VECS[i].per);
      wr(2'd2, VECS[i].div);
      wr(2'd3, VECS[i].cmp);
      wr(2'd0, {11'd0, VECS[i].ctrl});
      wait_n(int'(VECS[i].n));
      chk({tg, " cnt"}, cnt_o, int'(VECS[i].exp_cnt));
      chk({tg, " dir"}, dir_o, int'(VECS[i].exp_dir));
      chk({tg, " evt"}, evt_flag_o, int'(VECS[i].exp_evt));
      chk({tg, " cmpflag"}, cmp_flag_o, int'(VECS[i].exp_cmp));
    end

    // R12 R11: overflow pulse width, sticky flag, clear
    do_reset();
    wr(2'd1, 16'd5);
    wr(2'd0, 16'h0001);
    wait_n(6);
    chk("R12 ovf pulse", ovf_o, 1);
    chk("R12 unf quiet", unf_o, 0);
    chk("R3 wrap value", cnt_o, 0);
    wait_n(1);
    chk("R12 ovf one cycle", ovf_o, 0);
    chk("R11 flag held", evt_flag_o, 1);
    wait_n(3);
    chk("R11 flag still held", evt_flag_o, 1);
    evt_clr = 1'b1;
    @(negedge clk);
    evt_clr = 1'b0;
    chk("R11 flag cleared", evt_flag_o, 0);

    // R12 underflow pulse in down mode
    do_reset();
    wr(2'd1, 16'd5);
    wr(2'd0, 16'h0003);
    wait_n(1);
    chk("R12 unf pulse", unf_o, 1);
    chk("R12 ovf quiet", ovf_o, 0);
    chk("R4 reload", cnt_o, 5);

    // R8 unbuffered period takes effect at the next tick
    do_reset();
    wr(2'd1, 16'd10);
    wr(2'd0, 16'h0001);
    wait_n(3);
    wr(2'd1, 16'd2);
    chk("R8 count before", cnt_o, 4);
    wait_n(1);
    chk("R8 early wrap", cnt_o, 0);
    chk("R8 ovf", ovf_o, 1);

    // R9 buffered period waits for the next wrap
    do_reset();
    wr(2'd1, 16'd10);
    wr(2'd0, 16'h0011);
    wait_n(3);
    wr(2'd1, 16'd2);
    wait_n(6);
    chk("R9 old period kept", cnt_o, 10);
    wait_n(3);
    chk("R9 new period count", cnt_o, 2);
    wait_n(1);
    chk("R9 new period wrap", cnt_o, 0);
    chk("R9 ovf", ovf_o, 1);

    // R7 direction write ignored in up/down mode, honoured in edge mode
    do_reset();
    wr(2'd1, 16'd10);
    wr(2'd0, 16'h000D);
    wait_n(2);
    wr(2'd0, 16'h000F);
    chk("R7 dir write ignored", dir_o, 0);
    chk("R7 still rising", cnt_o, 3);
    wr(2'd0, 16'h0003);
    chk("R7 dir write edge mode", dir_o, 1);

    // R2 hold while disabled, divider restarts on enable
    do_reset();
    wr(2'd1, 16'd100);
    wr(2'd2, 16'd3);
    wr(2'd0, 16'h0001);
    wait_n(6);
    chk("R2 first step", cnt_o, 1);
    wr(2'd0, 16'h0000);
    wait_n(5);
    chk("R2 hold disabled", cnt_o, 1);
    wr(2'd0, 16'h0001);
    wait_n(3);
    chk("R2 restart no early step", cnt_o, 1);
    wait_n(1);
    chk("R2 restart step", cnt_o, 2);

    // R10 compare flag clear
    cmp_clr = 1'b1;
    @(negedge clk);
    cmp_clr = 1'b0;
    chk("R10 cmp flag cleared", cmp_flag_o, 0);

    finish_run();
  end
endmodule